// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects six interrupt sources: two external pins with selectable edge sensitivity, two timer overflow pulses, a converter-done pulse and a real-time tick. Each source latches its own request flag and has its own enable bit. A single master enable gates every source. Software reaches flags, enables and the master bit through two 8-bit control registers.

Toward the CPU the block offers a valid/ready request channel. `irq_valid` is high while the master enable is set, the return stack is not full, and at least one enabled flag is pending. `irq_vector` carries the fixed entry address of the highest-priority such source. The CPU takes the interrupt by raising `irq_ready`. A transfer happens on a clock edge where `irq_valid` and `irq_ready` are both high. On that edge the winning flag and the master enable are cleared. Before acceptance the vector may change if a higher-priority source becomes pending, and `irq_valid` may fall if the stack fills or software clears the flag. `irq_ready` is ignored while `irq_valid` is low.

A return pulse sets the master enable again, so a source still pending is offered next. The external pins are asynchronous. Each passes through a two-stage synchronizer and an edge detector, and their synchronizers reset to low.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, both control registers read 0x00 and `irq_valid` is low.
- R2: Control register 0 (`reg_sel`=0) holds the master enable in bit 0, enables for ext0/ext1/timer0 in bits 1/2/3, and flags for ext0/ext1/timer0 in bits 4/5/6. Control register 1 holds enables for timer1/adc/rtc in bits 1/2/3 and their flags in bits 4/5/6. All other bits read 0. A write replaces every writable bit of the selected register.
- R3: Priority runs ext0 > ext1 > timer0 > timer1 > adc > rtc. The vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and `irq_vector` shows the vector of the highest-priority source that is both enabled and pending.
- R4: `irq_valid` is high exactly when the master enable is set, `stack_full` is low and an enabled flag is pending. A flag sets whether or not its source or the master is enabled.
- R5: On acceptance (`irq_valid` and `irq_ready` high at a clock edge), the winning flag and the master enable clear, and all other flags keep their values.
- R6: While `stack_full` is high, `irq_valid` is low and `irq_ready` changes no flag and no enable.
- R7: A `reti` pulse sets the master enable, so a still-pending enabled source is presented on the next cycle.
- R8: An external pin mode value sets the edges that are detected: 00 none, 01 falling, 10 rising, 11 both. A qualifying pin change driven between edges shows in its flag after the third following rising clock edge.
- R9: A one-cycle pulse on `tmr0_ovf`, `tmr1_ovf`, `adc_done` or `rtc_tick` sets its flag at the next clock edge.
- R10: A source event in the same cycle as a software write or an acceptance that would clear its flag leaves the flag set.
- R11: Software setting the master enable while a handler runs allows a further acceptance, which is how nesting happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_pin | input | 1 | External interrupt pin 0 (asynchronous) |
| ext1_pin | input | 1 | External interrupt pin 1 (asynchronous) |
| ext0_mode | input | 2 | Edge select for pin 0 (00 none, 01 fall, 10 rise, 11 both) |
| ext1_mode | input | 2 | Edge select for pin 1 |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| adc_done | input | 1 | Converter completion pulse |
| rtc_tick | input | 1 | Real-time clock tick pulse |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | Control register select (0 or 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| stack_full | input | 1 | Return stack full; blocks acceptance |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | Interrupt request to the CPU |
| irq_ready | input | 1 | CPU takes the request |
| irq_vector | output | 8 | Entry address of the presented source |

## Verification
A corrupted flag or enable shows on `reg_rdata` as soon as its register is selected. If it belongs to the winning source, it also shows on `irq_valid` or `irq_vector` in the same cycle. A master bit stuck high lets a second acceptance through right after the first. A wrong synchronizer depth moves a pin flag one cycle early or late. The reference model compares every output on every cycle, so each of these faults is reported within one cycle of becoming visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC     = 6;
  localparam int N_EXT     = 2;
  localparam int BANK_SRC  = 3;
  localparam int IDX_W     = $clog2(N_SRC);
  localparam int EN_LSB    = 1;
  localparam int FLAG_LSB  = 4;

  typedef logic [N_SRC-1:0] src_vec_t;

  // mode bit 0 selects falling edges, bit 1 selects rising edges
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    cur  = sync_q[SYNC_STAGES-1];
    rise = cur & ~last_q;
    fall = ~cur & last_q;
    evt  = (mode[1] & rise) | (mode[0] & fall);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
(
  input  src_vec_t         req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output src_vec_t         grant
);
  // lowest index wins: index 0 has the highest priority
  always_comb begin
    idx   = '0;
    grant = '0;
    any   = |req;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  src_vec_t   evt,
  input  src_vec_t   clr,
  input  logic       accept,
  input  logic       reti,
  output src_vec_t   flag_q,
  output src_vec_t   en_q,
  output logic       master_q,
  output logic [7:0] reg_rdata
);
  src_vec_t flag_d;
  src_vec_t en_d;
  logic     master_d;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    for (int s = 0; s < N_SRC; s++) begin
      int  bank;
      int  pos;
      logic hit;
      bank = s / BANK_SRC;
      pos  = s % BANK_SRC;
      hit  = reg_we && (int'(reg_sel) == bank);
      if (hit) begin
        flag_d[s] = reg_wdata[FLAG_LSB + pos];
        en_d[s]   = reg_wdata[EN_LSB + pos];
      end
      // acceptance clears, a fresh event always wins
      flag_d[s] = (flag_d[s] & ~clr[s]) | evt[s];
    end
    if (accept)                      master_d = 1'b0;
    else if (reti)                   master_d = 1'b1;
    else if (reg_we && !reg_sel)     master_d = reg_wdata[0];
    else                             master_d = master_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      en_q     <= en_d;
      master_q <= master_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < BANK_SRC; p++) begin
      reg_rdata[EN_LSB + p]   = reg_sel ? en_q[BANK_SRC + p]   : en_q[p];
      reg_rdata[FLAG_LSB + p] = reg_sel ? flag_q[BANK_SRC + p] : flag_q[p];
    end
    reg_rdata[0] = reg_sel ? 1'b0 : master_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_pin,
  input  logic             ext1_pin,
  input  logic [1:0]       ext0_mode,
  input  logic [1:0]       ext1_mode,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             adc_done,
  input  logic             rtc_tick,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             stack_full,
  input  logic             reti,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector
);
  logic [N_EXT-1:0]       pins;
  logic [N_EXT-1:0][1:0]  modes;
  logic [N_EXT-1:0]       ext_evt;
  src_vec_t               evt;
  src_vec_t               flag_q;
  src_vec_t               en_q;
  src_vec_t               grant;
  src_vec_t               clr;
  logic                   master_q;
  logic                   any_req;
  logic [IDX_W-1:0]       win_idx;
  logic                   accept;

  assign pins  = {ext1_pin, ext0_pin};
  assign modes = {ext1_mode, ext0_mode};

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .mode (modes[g]),
      .evt  (ext_evt[g])
    );
  end

  assign evt = {rtc_tick, adc_done, tmr1_ovf, tmr0_ovf, ext_evt};

  irq_prio_pick u_pick (
    .req  (flag_q & en_q),
    .any  (any_req),
    .idx  (win_idx),
    .grant(grant)
  );

  assign irq_valid  = master_q & ~stack_full & any_req;
  assign accept     = irq_valid & irq_ready;
  assign clr        = accept ? grant : '0;
  assign irq_vector = VEC_W'((int'(win_idx) + 1) * VEC_STEP);

  irq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .evt      (evt),
    .clr      (clr),
    .accept   (accept),
    .reti     (reti),
    .flag_q   (flag_q),
    .en_q     (en_q),
    .master_q (master_q),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int VEC_W = 8,
  parameter int NS    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stack_full,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VEC_W-1:0] irq_vector,
  input logic             reti,
  input logic             master_q,
  input logic [NS-1:0]    flag_q,
  input logic             tmr0_ovf
);
  // R6
  stack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !irq_valid);

  // R4
  valid_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> master_q);

  // R5
  accept_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !master_q);

  // R7
  reti_sets_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(irq_valid && irq_ready)) |=> master_q);

  // R9
  timer0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> flag_q[2]);

  // R3
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_W'(4) && irq_vector <= VEC_W'(24)
                   && irq_vector[1:0] == 2'b00));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W), .NS(irq_pkg::N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stack_full(stack_full),
  .irq_valid (irq_valid),
  .irq_ready (irq_ready),
  .irq_vector(irq_vector),
  .reti      (reti),
  .master_q  (master_q),
  .flag_q    (flag_q),
  .tmr0_ovf  (tmr0_ovf)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext0_pin = 0, ext1_pin = 0;
  logic [1:0] ext0_mode = 0, ext1_mode = 0;
  logic       tmr0_ovf = 0, tmr1_ovf = 0, adc_done = 0, rtc_tick = 0;
  logic       reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       stack_full = 0, reti = 0, irq_ready = 0;
  logic       irq_valid;
  logic [7:0] irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit m_flag[6];
  bit m_en[6];
  bit m_me;
  bit m_ph[2][3];

  always #10 clk = ~clk;

  irq_arbiter dut (.*);

  function automatic int m_win();
    for (int i = 0; i < 6; i++) if (m_flag[i] && m_en[i]) return i;
    return -1;
  endfunction

  function automatic bit m_valid();
    return m_me && !stack_full && (m_win() >= 0);
  endfunction

  function automatic int m_rdata(bit sel);
    int r = 0;
    for (int p = 0; p < 3; p++) begin
      r |= int'(m_en[3*sel + p]) << (1 + p);
      r |= int'(m_flag[3*sel + p]) << (4 + p);
    end
    if (!sel) r |= int'(m_me);
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle with the inputs currently driven
  task automatic cyc();
    bit nf[6], nme, ev[6], acc;
    int w;
    logic [1:0] md;
    #1;
    check("R4 valid", int'(irq_valid), int'(m_valid()));
    if (m_valid()) check("R3 vector", int'(irq_vector), 4 * (m_win() + 1));
    check("R2 rdata", int'(reg_rdata), m_rdata(reg_sel));
    for (int e = 0; e < 2; e++) begin
      md = e ? ext1_mode : ext0_mode;
      ev[e] = (md[1] && m_ph[e][1] && !m_ph[e][2]) || (md[0] && !m_ph[e][1] && m_ph[e][2]);
    end
    ev[2] = tmr0_ovf; ev[3] = tmr1_ovf; ev[4] = adc_done; ev[5] = rtc_tick;
    w   = m_win();
    acc = m_valid() && irq_ready;
    for (int s = 0; s < 6; s++) begin
      nf[s] = m_flag[s];
      if (reg_we && int'(reg_sel) == s / 3) begin
        nf[s]   = reg_wdata[4 + s % 3];
        m_en[s] = reg_wdata[1 + s % 3];
      end
      if (acc && s == w) nf[s] = 1'b0;
      if (ev[s]) nf[s] = 1'b1;
    end
    if (acc) nme = 0;
    else if (reti) nme = 1;
    else if (reg_we && !reg_sel) nme = reg_wdata[0];
    else nme = m_me;
    @(posedge clk);
    m_flag = nf;
    m_me   = nme;
    for (int e = 0; e < 2; e++) begin
      m_ph[e][2] = m_ph[e][1];
      m_ph[e][1] = m_ph[e][0];
      m_ph[e][0] = e ? ext1_pin : ext0_pin;
    end
    @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_we = 0;
  endtask

  task automatic peek(bit sel, string tag, int exp);
    reg_sel = sel;
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    peek(0, "R1 ctrl0", 0);
    peek(1, "R1 ctrl1", 0);
    check("R1 valid", int'(irq_valid), 0);

    // R2: layout and write-back
    wr(0, 8'h0E); wr(1, 8'h0E);
    peek(0, "R2 ctrl0 enables", 8'h0E);
    peek(1, "R2 ctrl1 enables", 8'h0E);
    wr(1, 8'hFF);
    peek(1, "R2 unused bits zero", 8'h7E);
    wr(1, 8'h0E);
    peek(1, "R2 flags cleared by write", 8'h0E);

    // R9 + R4: timer0 pulse latches with master off, no request
    tmr0_ovf = 1; cyc(); tmr0_ovf = 0;
    peek(0, "R9 timer0 flag", 8'h4E);
    check("R4 no valid with master off", int'(irq_valid), 0);
    wr(0, 8'h4F);
    check("R4 valid with master on", int'(irq_valid), 1);
    check("R3 timer0 vector", int'(irq_vector), 8'h0C);

    // R8: falling-only mode ignores rise, latency on fall
    ext0_mode = 2'b01; ext0_pin = 1;
    repeat (4) cyc();
    peek(0, "R8 rise ignored in fall mode", 8'h4F);
    ext0_pin = 0;
    cyc(); cyc();
    peek(0, "R8 not yet after two edges", 8'h4F);
    cyc();
    peek(0, "R8 fall seen on third edge", 8'h5F);
    check("R3 ext0 outranks timer0", int'(irq_vector), 8'h04);

    // R6: stack full blocks request and ready
    stack_full = 1; irq_ready = 1;
    cyc();
    check("R6 valid low when full", int'(irq_valid), 0);
    cyc();
    peek(0, "R6 nothing cleared when full", 8'h5F);

    // R5: acceptance
    stack_full = 0;
    cyc(); irq_ready = 0;
    peek(0, "R5 winner flag and master cleared", 8'h4E);
    check("R5 valid low after accept", int'(irq_valid), 0);

    // R7: return re-enables and offers pending source
    reti = 1; cyc(); reti = 0;
    check("R7 valid after reti", int'(irq_valid), 1);
    check("R7 pending vector", int'(irq_vector), 8'h0C);
    irq_ready = 1; cyc(); irq_ready = 0;
    peek(0, "R5 timer0 accepted", 8'h0E);

    // R11: nesting by software master write
    rtc_tick = 1; cyc(); rtc_tick = 0;
    check("R11 held while master off", int'(irq_valid), 0);
    wr(0, 8'h0F);
    check("R11 valid after software enable", int'(irq_valid), 1);
    check("R11 rtc vector", int'(irq_vector), 8'h18);

    // R8: ext1 modes off / rise / both
    ext1_mode = 2'b00; ext1_pin = 1; repeat (4) cyc();
    ext1_pin = 0; repeat (4) cyc();
    peek(0, "R8 mode off sees nothing", 8'h0F);
    ext1_mode = 2'b10; ext1_pin = 1; repeat (4) cyc();
    peek(0, "R8 rising mode", 8'h2F);
    check("R3 ext1 vector", int'(irq_vector), 8'h08);
    wr(0, 8'h0F);
    ext1_mode = 2'b11; ext1_pin = 0; repeat (4) cyc();
    peek(0, "R8 both-edge mode on fall", 8'h2F);
    wr(0, 8'h0F);

    // R10: event beats software clear and acceptance clear
    tmr1_ovf = 1; reg_we = 1; reg_sel = 1; reg_wdata = 8'h0E;
    cyc(); tmr1_ovf = 0; reg_we = 0;
    peek(1, "R10 event beats write clear", 8'h1E);
    check("R3 timer1 vector", int'(irq_vector), 8'h10);
    tmr1_ovf = 1; irq_ready = 1; cyc(); tmr1_ovf = 0; irq_ready = 0;
    peek(1, "R10 event beats accept clear", 8'h1E);
    check("R10 master still cleared", int'(irq_valid), 0);

    // mixed traffic, compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      ext0_pin   = ($urandom % 5) == 0 ? ~ext0_pin : ext0_pin;
      ext1_pin   = ($urandom % 5) == 0 ? ~ext1_pin : ext1_pin;
      if (n % 500 == 0) begin ext0_mode = 2'($urandom); ext1_mode = 2'($urandom); end
      tmr0_ovf   = ($urandom % 9) == 0;
      tmr1_ovf   = ($urandom % 9) == 0;
      adc_done   = ($urandom % 11) == 0;
      rtc_tick   = ($urandom % 13) == 0;
      reg_we     = ($urandom % 7) == 0;
      reg_sel    = 1'($urandom);
      reg_wdata  = 8'($urandom);
      stack_full = ($urandom % 4) == 0;
      reti       = ($urandom % 6) == 0;
      irq_ready  = ($urandom % 3) == 0;
      cyc();
    end
    finish_run();
  end
endmodule